// File: doc/BRIEF.md
# Line Clamp and Horizontal Sync Regenerator

This block sits in the pixel clock domain behind a raw horizontal sync input. It brings the sync into the clock domain and decides which level of it is the active level, either from a user bit or by measuring the line itself. It then derives two timed strobes from the resulting active-high pulse.

The first strobe is a black-level clamp window. The window opens a programmable number of pixel clocks after the sync pulse ends and stays open for a programmable number of clocks. A select bit can replace this window with an externally supplied clamp. The second strobe is a regenerated sync pulse. It starts at the pulse's leading edge and has a programmable width.

All configuration inputs are treated as quasi-static. They are captured at every leading edge, so the line being timed always uses one consistent set of values.

Top module: `hcg_top`

## Requirements
- R1: The raw sync passes through a two-stage synchronizer. If the raw input first reads at its new (leading) level on clock edge k, `sync_out` is high from edge k+2.
- R2: `sync_out` stays high for exactly `cfg_width` clock cycles. A width of 0 produces no pulse.
- R3: If the raw input first reads at its trailing level on edge k, the internal clamp is high from edge k+1+P for `cfg_dur` cycles. P is the `cfg_place` value captured at the preceding leading edge, and a captured value of 0 is used as 1.
- R4: A captured clamp duration of 0 suppresses the internal clamp for that line.
- R5: While `cfg_clamp_ext_sel` is 1, `clamp_out` equals `clamp_ext`, and the placement and duration values have no effect on it. While the bit is 0, `clamp_out` is the internal clamp.
- R6: With effective polarity 0 (active low), the falling edge is the leading edge and the rising edge is the trailing edge. With polarity 1 (active high), these roles swap. A trailing edge never starts a `sync_out` pulse.
- R7: With `cfg_pol_force` = 1 the effective polarity is `cfg_pol_user`. With `cfg_pol_force` = 0 it is `pol_detected`.
- R8: Each rising edge of the synchronized sync closes a line. The level held for fewer cycles during that line is taken as the active level (1 = high is active; a tie counts as active low). `pol_detected` changes only when two consecutive measured lines agree, and never on the first rising edge after reset.
- R9: A new leading edge cancels any clamp that is waiting or running, and restarts the `sync_out` width count from the new edge.
- R10: Placement, duration and width are captured only at a leading edge. Changing them in the middle of a line does not alter the pulses of that line.
- R11: After a synchronous active-low reset, `sync_out` is 0, the internal clamp is 0 and `pol_detected` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_raw | input | 1 | Raw horizontal sync, asynchronous |
| clamp_ext | input | 1 | External clamp strobe |
| cfg_place | input | 8 | Clamp start delay after the trailing edge, in clocks |
| cfg_dur | input | 8 | Clamp length in clocks |
| cfg_width | input | 8 | Regenerated sync width in clocks |
| cfg_pol_user | input | 1 | User polarity: 1 active high, 0 active low |
| cfg_pol_force | input | 1 | 1 uses cfg_pol_user, 0 uses the detected polarity |
| cfg_clamp_ext_sel | input | 1 | 1 routes clamp_ext to clamp_out |
| clamp_out | output | 1 | Clamp strobe |
| sync_out | output | 1 | Regenerated active-high sync pulse |
| pol_detected | output | 1 | Detected sync polarity, 1 = active high |

## Verification
Each timer value, latched register or level count that goes wrong appears at a port within the same line. A bad width count or a missed edge shows up on `sync_out` within the first pulse. A wrong delay or length count moves an edge of `clamp_out` by a countable number of clocks. A polarity decision that is wrong or arrives early flips `pol_detected` on a specific line edge, and the false polarity then moves both strobes one line later. A behavioural model in the bench predicts all three outputs on every clock, so an error is reported in the cycle where it first reaches a port.

// File: rtl/hcg_pkg.sv
// Shared types for the clamp and sync regenerator.
// Assumes: nothing beyond IEEE 1800-2017.
package hcg_pkg;
    typedef enum logic [1:0] {
        CL_IDLE = 2'd0,
        CL_WAIT = 2'd1,
        CL_ON   = 2'd2
    } clamp_st_t;
endpackage

// File: rtl/hcg_sync_edge.sv
// Brings the raw sync into the clock domain through a flop chain and flags
// rising and falling edges of the synchronized level.
// Assumes: SYNC_STAGES >= 2; raw input has no timing relation to clk.
module hcg_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    // Shift the raw level through the chain and keep the last synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[TOP-1:0], raw_i};
            prev  <= chain[TOP];
        end
    end

    assign lvl_o  = chain[TOP];
    assign rise_o = chain[TOP] & ~prev;
    assign fall_o = ~chain[TOP] & prev;

    // An edge flag lasts a single cycle.
    assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o |=> !rise_o));
    assert_fall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o |=> !fall_o));
endmodule

// File: rtl/hcg_pol_detect.sv
// Measures high and low time of the synchronized sync per line (line closes
// on each rising edge) and adopts the shorter level as active once two lines agree.
// Assumes: counters saturate on very long lines; tie counts as active low.
module hcg_pol_detect #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic rise_i,
    output logic det_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] hi_cnt, lo_cnt;
    logic             seen, cand_vld, cand_last, det;
    logic             cand_now;

    assign cand_now = (hi_cnt < lo_cnt);

    // Count level time, close the line on a rising edge and vote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            seen      <= 1'b0;
            cand_vld  <= 1'b0;
            cand_last <= 1'b1;
            det       <= 1'b1;
        end else if (rise_i) begin
            if (seen) begin
                if (cand_vld && (cand_now == cand_last)) det <= cand_now;
                cand_last <= cand_now;
                cand_vld  <= 1'b1;
            end
            seen   <= 1'b1;
            hi_cnt <= CNT_ONE;
            lo_cnt <= '0;
        end else if (lvl_i) begin
            if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + CNT_ONE;
        end else begin
            if (lo_cnt != CNT_MAX) lo_cnt <= lo_cnt + CNT_ONE;
        end
    end

    assign det_o = det;

    // The decision only moves at a line boundary.
    assert_det_at_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(det_o) |-> $past(rise_i)));
endmodule

// File: rtl/hcg_width_timer.sv
// Regenerated sync pulse: high for len_i cycles after start_i, restarting
// on every start.
// Assumes: len_i is valid in the start cycle.
module hcg_width_timer #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [REG_W-1:0] len_i,
    output logic             pulse_o
);
    logic [REG_W-1:0] cnt;

    // Load on start, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start_i)    cnt <= len_i;
        else if (cnt != '0)  cnt <= cnt - REG_W'(1);
    end

    assign pulse_o = (cnt != '0);

    assert_zero_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (len_i == '0) |=> !pulse_o));
    assert_pulse_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_o) |-> $past(start_i)));
endmodule

// File: rtl/hcg_clamp_timer.sv
// Internal clamp window: captures placement and duration at the leading edge,
// waits placement clocks after the trailing edge, then stays high for duration.
// Assumes: leading and trailing flags never coincide.
module hcg_clamp_timer
    import hcg_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lead_i,
    input  logic             trail_i,
    input  logic [REG_W-1:0] place_i,
    input  logic [REG_W-1:0] dur_i,
    output logic             clamp_o
);
    localparam logic [REG_W-1:0] ONE = REG_W'(1);

    logic [REG_W-1:0] place_q, dur_q, cnt;
    clamp_st_t        st;

    // Capture settings at the leading edge; run wait/on phases from the trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            place_q <= ONE;
            dur_q   <= '0;
            cnt     <= '0;
            st      <= CL_IDLE;
        end else if (lead_i) begin
            place_q <= (place_i == '0) ? ONE : place_i;
            dur_q   <= dur_i;
            cnt     <= '0;
            st      <= CL_IDLE;
        end else if (trail_i) begin
            if (dur_q == '0) begin
                st  <= CL_IDLE;
                cnt <= '0;
            end else if (place_q == ONE) begin
                st  <= CL_ON;
                cnt <= dur_q;
            end else begin
                st  <= CL_WAIT;
                cnt <= place_q - ONE;
            end
        end else begin
            case (st)
                CL_WAIT: begin
                    if (cnt == ONE) begin
                        st  <= CL_ON;
                        cnt <= dur_q;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                CL_ON: begin
                    if (cnt == ONE) begin
                        st  <= CL_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign clamp_o = (st == CL_ON);

    assert_lead_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_i |=> !clamp_o));
    assert_zero_dur_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_i && (dur_q == '0) |=> !clamp_o));
endmodule

// File: rtl/hcg_top.sv
// Line clamp and sync regenerator top: synchronizer, polarity choice,
// clamp window timer and output width timer.
// Assumes: configuration inputs are quasi-static and single-clock.
module hcg_top #(
    parameter int REG_W       = 8,
    parameter int LINE_CNT_W  = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_raw,
    input  logic             clamp_ext,
    input  logic [REG_W-1:0] cfg_place,
    input  logic [REG_W-1:0] cfg_dur,
    input  logic [REG_W-1:0] cfg_width,
    input  logic             cfg_pol_user,
    input  logic             cfg_pol_force,
    input  logic             cfg_clamp_ext_sel,
    output logic             clamp_out,
    output logic             sync_out,
    output logic             pol_detected
);
    logic lvl, rise, fall;
    logic det, pol_eff, lead, trail, clamp_int;

    hcg_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(sync_raw),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    hcg_pol_detect #(.CNT_W(LINE_CNT_W)) u_pol (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_i(rise), .det_o(det)
    );

    // Pick the polarity source and classify edges as leading or trailing.
    always_comb begin
        pol_eff = cfg_pol_force ? cfg_pol_user : det;
        lead    = pol_eff ? rise : fall;
        trail   = pol_eff ? fall : rise;
    end

    hcg_width_timer #(.REG_W(REG_W)) u_width (
        .clk(clk), .rst_n(rst_n), .start_i(lead), .len_i(cfg_width),
        .pulse_o(sync_out)
    );

    hcg_clamp_timer #(.REG_W(REG_W)) u_clamp (
        .clk(clk), .rst_n(rst_n), .lead_i(lead), .trail_i(trail),
        .place_i(cfg_place), .dur_i(cfg_dur), .clamp_o(clamp_int)
    );

    assign clamp_out    = cfg_clamp_ext_sel ? clamp_ext : clamp_int;
    assign pol_detected = det;
endmodule

// File: tb/tb_hcg_top.sv
`timescale 1ns/1ps
module tb_hcg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_raw = 1'b0;
    logic       clamp_ext = 1'b0;
    logic [7:0] cfg_place = 8'd3;
    logic [7:0] cfg_dur = 8'd4;
    logic [7:0] cfg_width = 8'd5;
    logic       cfg_pol_user = 1'b1;
    logic       cfg_pol_force = 1'b1;
    logic       cfg_clamp_ext_sel = 1'b0;
    logic       clamp_out, sync_out, pol_detected;

    int    checks = 0;
    int    failures = 0;
    bit    cmp_en = 0;
    bit    done = 0;
    string cur_req = "R11";

    always #2.5 clk = ~clk;

    hcg_top dut (
        .clk(clk), .rst_n(rst_n), .sync_raw(sync_raw), .clamp_ext(clamp_ext),
        .cfg_place(cfg_place), .cfg_dur(cfg_dur), .cfg_width(cfg_width),
        .cfg_pol_user(cfg_pol_user), .cfg_pol_force(cfg_pol_force),
        .cfg_clamp_ext_sel(cfg_clamp_ext_sel), .clamp_out(clamp_out),
        .sync_out(sync_out), .pol_detected(pol_detected)
    );

    // Behavioural reference model, advanced on each rising clock edge.
    bit hist[$];
    int m_hi, m_lo, m_place, m_dur, m_wait, m_left, m_slen;
    bit m_seen, m_cvld, m_clast, m_det;

    task automatic model_edge();
        bit lvl, prv, rise, fall, pol, lead, trail, cand;
        if (!rst_n) begin
            hist = {1'b0, 1'b0, 1'b0};
            m_hi = 0; m_lo = 0; m_seen = 0; m_cvld = 0; m_clast = 1; m_det = 1;
            m_place = 1; m_dur = 0; m_wait = 0; m_left = 0; m_slen = 0;
            return;
        end
        hist.push_back(sync_raw);
        while (hist.size() > 4) void'(hist.pop_front());
        lvl = hist[hist.size()-3];
        prv = hist[hist.size()-4];
        rise = lvl && !prv;
        fall = !lvl && prv;
        pol = cfg_pol_force ? cfg_pol_user : m_det;
        lead = pol ? rise : fall;
        trail = pol ? fall : rise;
        if (lead) m_slen = cfg_width;
        else if (m_slen > 0) m_slen--;
        if (lead) begin
            m_place = (cfg_place == 0) ? 1 : int'(cfg_place);
            m_dur = cfg_dur; m_wait = 0; m_left = 0;
        end else if (trail) begin
            m_wait = m_place - 1; m_left = m_dur;
        end else if (m_wait > 0) m_wait--;
        else if (m_left > 0) m_left--;
        if (rise) begin
            if (m_seen) begin
                cand = (m_hi < m_lo);
                if (m_cvld && cand == m_clast) m_det = cand;
                m_clast = cand; m_cvld = 1;
            end
            m_seen = 1; m_hi = 1; m_lo = 0;
        end else if (lvl) begin
            if (m_hi < 4095) m_hi++;
        end else if (m_lo < 4095) m_lo++;
    endtask

    always @(posedge clk) model_edge();

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check(cur_req, "sync_out", sync_out, m_slen > 0);
            check(cur_req, "clamp_out", clamp_out,
                  cfg_clamp_ext_sel ? clamp_ext : (m_wait == 0 && m_left > 0));
            check(cur_req, "pol_detected", pol_detected, m_det);
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic line(bit act, int a, int i);
        sync_raw = act; cyc(a);
        sync_raw = !act; cyc(i);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        @(posedge clk); #1;
        cmp_en = 1;
        cur_req = "R11";
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 R2 R3: active-high lines with forced polarity
        cur_req = "R1"; line(1, 6, 30);
        cur_req = "R3"; line(1, 6, 30);
        cur_req = "R2"; cfg_width = 8'd0; line(1, 6, 20);
        cfg_width = 8'd1; line(1, 6, 20);
        cur_req = "R3"; cfg_place = 8'd0; cfg_width = 8'd5; line(1, 6, 20);
        cfg_place = 8'd255; cfg_dur = 8'd3; line(1, 4, 270);
        cur_req = "R4"; cfg_place = 8'd2; cfg_dur = 8'd0; line(1, 6, 20);
        // R5: external clamp routed through, internal settings irrelevant
        cur_req = "R5"; cfg_dur = 8'd6; cfg_clamp_ext_sel = 1'b1;
        sync_raw = 1'b1; cyc(3); clamp_ext = 1'b1; cyc(2);
        sync_raw = 1'b0; clamp_ext = 1'b0; cyc(4); clamp_ext = 1'b1; cyc(5);
        clamp_ext = 1'b0; cyc(10); cfg_clamp_ext_sel = 1'b0;
        // R6: forced active low, idle level high
        cur_req = "R6"; cfg_pol_user = 1'b0; sync_raw = 1'b1; cyc(20);
        line(0, 6, 30); line(0, 6, 30);
        // R9: next leading edge lands inside clamp and width windows
        cur_req = "R9"; cfg_pol_user = 1'b1; sync_raw = 1'b0; cyc(20);
        cfg_place = 8'd3; cfg_dur = 8'd20; cfg_width = 8'd40;
        line(1, 4, 8); line(1, 4, 8); line(1, 4, 30); cyc(30);
        // R10: settings change mid-line
        cur_req = "R10"; cfg_place = 8'd2; cfg_dur = 8'd5; cfg_width = 8'd6;
        sync_raw = 1'b1; cyc(3);
        cfg_place = 8'd9; cfg_dur = 8'd1; cfg_width = 8'd2;
        cyc(3); sync_raw = 1'b0; cyc(4); cfg_dur = 8'd12; cyc(20);
        line(1, 6, 30);
        // R7 R8: automatic detection of active-low sync
        cur_req = "R8"; cfg_pol_force = 1'b0; cfg_place = 8'd3; cfg_dur = 8'd4;
        cfg_width = 8'd5; sync_raw = 1'b1; cyc(10);
        line(0, 5, 40); line(0, 5, 40); line(0, 5, 40); line(0, 5, 40);
        cur_req = "R7"; check("R8", "pol after low lines", pol_detected, 1'b0);
        line(0, 5, 40);
        // R8: switch back to active-high sync and confirm the flip back
        cur_req = "R8"; sync_raw = 1'b0; cyc(10);
        line(1, 5, 40); line(1, 5, 40); line(1, 5, 40); line(1, 5, 40);
        cur_req = "R7"; check("R8", "pol after high lines", pol_detected, 1'b1);
        line(1, 5, 40);
        // R7: forced user bit overrides the detected polarity
        cfg_pol_force = 1'b1; cfg_pol_user = 1'b0; sync_raw = 1'b1; cyc(10);
        line(0, 5, 30);
        // R11: reset again in the middle of activity
        cur_req = "R11"; sync_raw = 1'b0; rst_n = 1'b0; cyc(3);
        @(negedge clk);
        check("R11", "sync_out in reset", sync_out, 1'b0);
        check("R11", "pol in reset", pol_detected, 1'b1);
        check("R11", "clamp in reset", clamp_out, 1'b0);
        @(posedge clk); #1;
        finish_run();
    end
endmodule